// File: doc/BRIEF.md
# Level Crossing Securing Handshake Controller

This block pairs a crossing-side controller with a train-side controller and runs the handshake that secures a level crossing before a train passes. A start pulse makes the train send an enable request. The crossing acknowledges it, commands the barrier down and switches the lights on. After a fixed securing time the train sends a status query. The crossing answers with a safe message only when the barrier reports closed and no fault is present. If no safe answer comes back within a reply window, the train stops and waits for a driver release before moving on.

Messages are one-cycle strobes. They travel through a registered channel stage in each direction, and that stage can drop any message while its drop input is high. A pass sensor pulse ends the round on both sides. The crossing lowers its lights, and the barrier sub-controller reopens even from its fault state, so a new round can start without delay.

Top module: `lx_secure_top`

## Requirements
- R1: In the train idle state a `trip` pulse makes `enable_sent` pulse one cycle later. A `trip` pulse while a round is running produces no further `enable_sent`.
- R2: A delivered enable request makes `ack_sent` and `lights_on` rise 2 cycles after `enable_sent`, and `barrier_lower` rise 3 cycles after it.
- R3: After a delivered acknowledge, `status_sent` pulses exactly SECURE_CYCLES+2 cycles after `ack_sent`.
- R4: On a delivered status query, `safe_sent` pulses 2 cycles after `status_sent` if `barrier_closed` is 1 and `barrier_fault` is 0. Otherwise no safe reply is sent.
- R5: A delivered safe reply makes `train_go` rise 2 cycles after `safe_sent`, and `train_stopped` stays 0 for the round.
- R6: If no safe reply arrives, `train_stopped` rises exactly REPLY_TIMEOUT cycles after `status_sent`.
- R7: `train_stopped` holds until `driver_release` is sampled high. One cycle later `train_go` is 1 and `train_stopped` is 0.
- R8: A `pass_sensor` pulse during a round clears `lights_on` and `train_go` one cycle later and `barrier_lower` two cycles later, even when the barrier is in its fault state.
- R9: If no acknowledge arrives, `train_stopped` rises exactly REPLY_TIMEOUT cycles after `enable_sent`.
- R10: A message is lost when the drop input of its direction (`drop_to_crossing` for enable and status, `drop_to_train` for acknowledge and safe) is high in the cycle its strobe is high.
- R11: `barrier_alarm` rises one cycle after `barrier_lower` when `barrier_fault` is high while the barrier is lowering or down, and it clears together with `barrier_lower` on reopen.
- R12: A round that follows a faulted round is acknowledged and completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trip | input | 1 | Train start pulse |
| driver_release | input | 1 | Driver confirms it is safe to continue |
| pass_sensor | input | 1 | Train has passed the crossing |
| barrier_closed | input | 1 | Barrier reports closed |
| barrier_fault | input | 1 | Barrier reports a fault |
| drop_to_crossing | input | 1 | Drop train-to-crossing messages |
| drop_to_train | input | 1 | Drop crossing-to-train messages |
| enable_sent | output | 1 | Train sent enable request |
| ack_sent | output | 1 | Crossing sent acknowledge |
| status_sent | output | 1 | Train sent status query |
| safe_sent | output | 1 | Crossing sent safe reply |
| barrier_lower | output | 1 | Barrier down command |
| lights_on | output | 1 | Warning lights command |
| barrier_alarm | output | 1 | Barrier in fault state |
| train_stopped | output | 1 | Train halted before the crossing |
| train_go | output | 1 | Train cleared to run |

## Verification
A wrong internal state shows at the ports as a message strobe, a stop or a go that appears in the wrong cycle, or never appears. Examples are an off-by-one securing or reply counter, or a branch taken on the wrong reply. The bench measures each of these distances in exact cycles. A barrier controller that leaves its fault state too early, or ignores the open command, shows up within two cycles of the pass pulse as a `barrier_lower` that stays high. In the following round it also shows as a crossing that no longer behaves normally. Each case is checked in both the direct-safe branch and the stop branch.

// File: rtl/lx_pkg.sv
package lx_pkg;
  typedef enum logic [2:0] {
    T_IDLE, T_WAIT_ACK, T_SECURE_WAIT, T_WAIT_REPLY, T_STOPPED, T_PROCEED
  } train_st_e;

  typedef enum logic {
    C_IDLE, C_ARMED
  } cross_st_e;

  typedef enum logic [1:0] {
    B_UP, B_LOWERING, B_DOWN, B_FAULT
  } bar_st_e;
endpackage

// File: rtl/lx_channel.sv
module lx_channel #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] tx,
  input  logic             drop,
  output logic [LANES-1:0] rx
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) rx[g] <= 1'b0;
      else     rx[g] <= tx[g] & ~drop;
    end

    assert_drop_loses_R10: assert property (@(posedge clk) disable iff (rst)
      (tx[g] && drop) |=> !rx[g]);
    assert_delivered_R10: assert property (@(posedge clk) disable iff (rst)
      (tx[g] && !drop) |=> rx[g]);
  end
endmodule

// File: rtl/lx_barrier.sv
module lx_barrier
  import lx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic close_req,
  input  logic open_req,
  input  logic closed_in,
  input  logic fault_in,
  output logic lowered,
  output logic alarm
);
  bar_st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= B_UP;
    end else if (open_req) begin
      st <= B_UP;
    end else begin
      case (st)
        B_UP:       if (close_req) st <= B_LOWERING;
        B_LOWERING: if (fault_in) st <= B_FAULT;
                    else if (closed_in) st <= B_DOWN;
        B_DOWN:     if (fault_in) st <= B_FAULT;
        B_FAULT:    st <= B_FAULT;
        default:    st <= B_UP;
      endcase
    end
  end

  assign lowered = (st != B_UP);
  assign alarm   = (st == B_FAULT);

  assert_open_obeyed_R8: assert property (@(posedge clk) disable iff (rst)
    open_req |=> !lowered);
  assert_fault_held_R11: assert property (@(posedge clk) disable iff (rst)
    (alarm && !open_req) |=> alarm);
endmodule

// File: rtl/lx_crossing.sv
module lx_crossing
  import lx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rx_enable,
  input  logic rx_status,
  input  logic pass_sensor,
  input  logic barrier_closed,
  input  logic barrier_fault,
  output logic tx_ack,
  output logic tx_safe,
  output logic lights_on,
  output logic barrier_lower,
  output logic barrier_alarm
);
  cross_st_e st;
  logic close_req, open_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= C_IDLE;
      tx_ack    <= 1'b0;
      tx_safe   <= 1'b0;
      close_req <= 1'b0;
      open_req  <= 1'b0;
      lights_on <= 1'b0;
    end else begin
      tx_ack    <= 1'b0;
      tx_safe   <= 1'b0;
      close_req <= 1'b0;
      open_req  <= 1'b0;
      case (st)
        C_IDLE: begin
          if (rx_enable) begin
            tx_ack    <= 1'b1;
            close_req <= 1'b1;
            lights_on <= 1'b1;
            st        <= C_ARMED;
          end
        end
        C_ARMED: begin
          if (rx_status && barrier_closed && !barrier_fault) tx_safe <= 1'b1;
          if (pass_sensor) begin
            open_req  <= 1'b1;
            lights_on <= 1'b0;
            st        <= C_IDLE;
          end
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  lx_barrier u_barrier (
    .clk       (clk),
    .rst       (rst),
    .close_req (close_req),
    .open_req  (open_req),
    .closed_in (barrier_closed),
    .fault_in  (barrier_fault),
    .lowered   (barrier_lower),
    .alarm     (barrier_alarm)
  );

  assert_busy_ignores_enable_R1: assert property (@(posedge clk) disable iff (rst)
    (st == C_ARMED && rx_enable) |=> !tx_ack);
  assert_safe_follows_query_R4: assert property (@(posedge clk) disable iff (rst)
    tx_safe |-> $past(rx_status));
  assert_pass_darkens_R8: assert property (@(posedge clk) disable iff (rst)
    (st == C_ARMED && pass_sensor) |=> !lights_on);
endmodule

// File: rtl/lx_train.sv
module lx_train
  import lx_pkg::*;
#(
  parameter int SECURE_CYCLES = 6,
  parameter int REPLY_TIMEOUT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic trip,
  input  logic rx_ack,
  input  logic rx_safe,
  input  logic driver_release,
  input  logic pass_sensor,
  output logic tx_enable,
  output logic tx_status,
  output logic stopped,
  output logic go
);
  localparam int MAXC  = (SECURE_CYCLES > REPLY_TIMEOUT) ? SECURE_CYCLES : REPLY_TIMEOUT;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] SEC_LAST = CNT_W'(SECURE_CYCLES - 1);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(REPLY_TIMEOUT - 1);

  train_st_e st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= T_IDLE;
      cnt       <= '0;
      tx_enable <= 1'b0;
      tx_status <= 1'b0;
      stopped   <= 1'b0;
      go        <= 1'b0;
    end else begin
      tx_enable <= 1'b0;
      tx_status <= 1'b0;
      case (st)
        T_IDLE: begin
          if (trip) begin
            tx_enable <= 1'b1;
            cnt       <= '0;
            st        <= T_WAIT_ACK;
          end
        end
        T_WAIT_ACK: begin
          if (rx_ack) begin
            cnt <= '0;
            st  <= T_SECURE_WAIT;
          end else if (cnt == TMO_LAST) begin
            stopped <= 1'b1;
            st      <= T_STOPPED;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        T_SECURE_WAIT: begin
          if (cnt == SEC_LAST) begin
            tx_status <= 1'b1;
            cnt       <= '0;
            st        <= T_WAIT_REPLY;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        T_WAIT_REPLY: begin
          if (rx_safe) begin
            go <= 1'b1;
            st <= T_PROCEED;
          end else if (cnt == TMO_LAST) begin
            stopped <= 1'b1;
            st      <= T_STOPPED;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        T_STOPPED: begin
          if (driver_release) begin
            stopped <= 1'b0;
            go      <= 1'b1;
            st      <= T_PROCEED;
          end
        end
        T_PROCEED: begin
          if (pass_sensor) begin
            go <= 1'b0;
            st <= T_IDLE;
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  assert_enable_single_R1: assert property (@(posedge clk) disable iff (rst)
    tx_enable |=> !tx_enable);
  assert_status_single_R3: assert property (@(posedge clk) disable iff (rst)
    tx_status |=> !tx_status);
  assert_go_excludes_stop_R5: assert property (@(posedge clk) disable iff (rst)
    go |-> !stopped);
  assert_stop_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (stopped && !driver_release) |=> stopped);
  assert_release_runs_R7: assert property (@(posedge clk) disable iff (rst)
    (stopped && driver_release) |=> go);
endmodule

// File: rtl/lx_secure_top.sv
module lx_secure_top #(
  parameter int SECURE_CYCLES = 6,
  parameter int REPLY_TIMEOUT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic trip,
  input  logic driver_release,
  input  logic pass_sensor,
  input  logic barrier_closed,
  input  logic barrier_fault,
  input  logic drop_to_crossing,
  input  logic drop_to_train,
  output logic enable_sent,
  output logic ack_sent,
  output logic status_sent,
  output logic safe_sent,
  output logic barrier_lower,
  output logic lights_on,
  output logic barrier_alarm,
  output logic train_stopped,
  output logic train_go
);
  localparam int LANES = 2;

  logic [LANES-1:0] t2c_tx, t2c_rx, c2t_tx, c2t_rx;

  assign t2c_tx = {status_sent, enable_sent};
  assign c2t_tx = {safe_sent, ack_sent};

  lx_train #(
    .SECURE_CYCLES (SECURE_CYCLES),
    .REPLY_TIMEOUT (REPLY_TIMEOUT)
  ) u_train (
    .clk            (clk),
    .rst            (rst),
    .trip           (trip),
    .rx_ack         (c2t_rx[0]),
    .rx_safe        (c2t_rx[1]),
    .driver_release (driver_release),
    .pass_sensor    (pass_sensor),
    .tx_enable      (enable_sent),
    .tx_status      (status_sent),
    .stopped        (train_stopped),
    .go             (train_go)
  );

  lx_channel #(.LANES(LANES)) u_to_crossing (
    .clk  (clk),
    .rst  (rst),
    .tx   (t2c_tx),
    .drop (drop_to_crossing),
    .rx   (t2c_rx)
  );

  lx_channel #(.LANES(LANES)) u_to_train (
    .clk  (clk),
    .rst  (rst),
    .tx   (c2t_tx),
    .drop (drop_to_train),
    .rx   (c2t_rx)
  );

  lx_crossing u_crossing (
    .clk            (clk),
    .rst            (rst),
    .rx_enable      (t2c_rx[0]),
    .rx_status      (t2c_rx[1]),
    .pass_sensor    (pass_sensor),
    .barrier_closed (barrier_closed),
    .barrier_fault  (barrier_fault),
    .tx_ack         (ack_sent),
    .tx_safe        (safe_sent),
    .lights_on      (lights_on),
    .barrier_lower  (barrier_lower),
    .barrier_alarm  (barrier_alarm)
  );

  assert_ack_after_enable_R2: assert property (@(posedge clk) disable iff (rst)
    ack_sent |-> $past(t2c_rx[0]));
  assert_alarm_implies_lowered_R11: assert property (@(posedge clk) disable iff (rst)
    barrier_alarm |-> barrier_lower);
endmodule

// File: tb/test_lx_secure_top.sv
module test_lx_secure_top;
  localparam int S = 6;
  localparam int T = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trip = 0, driver_release = 0, pass_sensor = 0;
  logic barrier_closed = 0, barrier_fault = 0;
  logic drop_to_crossing = 0, drop_to_train = 0;
  logic enable_sent, ack_sent, status_sent, safe_sent;
  logic barrier_lower, lights_on, barrier_alarm, train_stopped, train_go;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lx_secure_top #(.SECURE_CYCLES(S), .REPLY_TIMEOUT(T)) i_lx_secure_top (
    .clk(clk), .rst(rst), .trip(trip), .driver_release(driver_release),
    .pass_sensor(pass_sensor), .barrier_closed(barrier_closed),
    .barrier_fault(barrier_fault), .drop_to_crossing(drop_to_crossing),
    .drop_to_train(drop_to_train), .enable_sent(enable_sent),
    .ack_sent(ack_sent), .status_sent(status_sent), .safe_sent(safe_sent),
    .barrier_lower(barrier_lower), .lights_on(lights_on),
    .barrier_alarm(barrier_alarm), .train_stopped(train_stopped),
    .train_go(train_go)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic run_round(input bit fault, input bit closed, input bit den,
                           input bit dack, input bit dstat, input bit dsafe,
                           input bit retrig);
    int t_en = -1, t_ack = -1, t_stat = -1, t_safe = -1, t_go = -1, t_stop = -1;
    int t_low = -1, t_alarm = -1, t_light = -1;
    int n_en = 0;
    bit ack_exp, stat_exp, safe_exp, go_exp;
    barrier_fault    = fault;
    barrier_closed   = closed;
    drop_to_crossing = den;
    drop_to_train    = dack;
    trip = 1;
    @(negedge clk);
    trip = 0;
    for (int k = 0; k < S + T + 24; k++) begin
      if (enable_sent) begin n_en++; if (t_en < 0) t_en = cyc; end
      if (ack_sent && t_ack < 0) t_ack = cyc;
      if (status_sent && t_stat < 0) t_stat = cyc;
      if (safe_sent && t_safe < 0) t_safe = cyc;
      if (train_go && t_go < 0) t_go = cyc;
      if (train_stopped && t_stop < 0) t_stop = cyc;
      if (barrier_lower && t_low < 0) t_low = cyc;
      if (barrier_alarm && t_alarm < 0) t_alarm = cyc;
      if (lights_on && t_light < 0) t_light = cyc;
      if (t_ack >= 0 && cyc == t_ack + 1) begin
        drop_to_crossing = dstat;
        drop_to_train    = dsafe;
      end
      trip = (retrig && t_en >= 0 && cyc == t_en + 3);
      @(negedge clk);
    end
    trip = 0;
    drop_to_crossing = 0;
    drop_to_train = 0;

    ack_exp  = !den;
    stat_exp = ack_exp && !dack;
    safe_exp = stat_exp && !dstat && closed && !fault;
    go_exp   = safe_exp && !dsafe;

    chk(n_en == 1, "R1 enable count", n_en, 1);
    chk((t_ack >= 0) == ack_exp, "R10 ack presence", t_ack >= 0, ack_exp);
    if (ack_exp) begin
      chk(t_ack - t_en == 2, "R2 ack delay", t_ack - t_en, 2);
      chk(t_light - t_en == 2, "R2 lights delay", t_light - t_en, 2);
      chk(t_low - t_en == 3, "R2 barrier delay", t_low - t_en, 3);
    end else begin
      chk(t_low < 0 && t_light < 0, "R10 crossing untouched", t_low, -1);
    end
    chk((t_stat >= 0) == stat_exp, "R3 status presence", t_stat >= 0, stat_exp);
    if (stat_exp) chk(t_stat - t_ack == S + 2, "R3 status delay", t_stat - t_ack, S + 2);
    chk((t_safe >= 0) == safe_exp, "R4 safe presence", t_safe >= 0, safe_exp);
    if (safe_exp) chk(t_safe - t_stat == 2, "R4 safe delay", t_safe - t_stat, 2);
    if (ack_exp && fault)
      chk(t_alarm - t_low == 1, "R11 alarm delay", t_alarm - t_low, 1);
    else
      chk(t_alarm < 0, "R11 no alarm", t_alarm, -1);
    if (go_exp) begin
      chk(t_go - t_safe == 2, "R5 go delay", t_go - t_safe, 2);
      chk(t_stop < 0, "R5 never stopped", t_stop, -1);
    end else begin
      chk(t_go < 0, "R6 no go before release", t_go, -1);
      if (stat_exp)
        chk(t_stop - t_stat == T, "R6 stop after status", t_stop - t_stat, T);
      else
        chk(t_stop - t_en == T, "R9 stop after enable", t_stop - t_en, T);
      chk(train_stopped == 1, "R7 stop held", train_stopped, 1);
      driver_release = 1;
      @(negedge clk);
      driver_release = 0;
      chk(train_go == 1 && train_stopped == 0, "R7 release", train_go, 1);
    end
    pass_sensor = 1;
    @(negedge clk);
    pass_sensor = 0;
    chk(lights_on == 0, "R8 lights off", lights_on, 0);
    chk(train_go == 0, "R8 go off", train_go, 0);
    chk(barrier_lower == ack_exp, "R8 barrier still held one cycle", barrier_lower, ack_exp);
    @(negedge clk);
    chk(barrier_lower == 0, "R8 barrier reopened", barrier_lower, 0);
    chk(barrier_alarm == 0, "R11 alarm cleared", barrier_alarm, 0);
    barrier_fault = 0;
    barrier_closed = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk({enable_sent, ack_sent, status_sent, safe_sent, barrier_lower, lights_on,
         barrier_alarm, train_stopped, train_go} == 9'b0, "R1 reset outputs", 0, 0);
    for (int f = 0; f < 2; f++)
      for (int c = 0; c < 2; c++)
        run_round(f[0], c[0], 0, 0, 0, 0, 0);
    for (int d = 0; d < 4; d++)
      run_round(0, 1, d == 0, d == 1, d == 2, d == 3, 0);
    run_round(0, 1, 0, 0, 0, 0, 1);
    run_round(1, 0, 0, 0, 0, 0, 0);
    // R12: round after a faulted round completes on the safe branch
    run_round(0, 1, 0, 0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule